// File: doc/BRIEF.md
# Two-Colour Bar and Ramp Test Pattern Generator

This block sits in a display pipe after the timing generator and, when enabled, replaces the incoming video with a synthetic picture. The picture is a function of the current pixel column and line. It can show vertical or horizontal bars that alternate between two programmable RGB colours, or a grey ramp across the line. The ramp comes in a single-ramp form and in a dual-ramp form, where the upper and lower bands of each pair of bands use different slopes and starting levels. When the enable is low, the input video passes through unchanged. In both cases the output is one register stage behind the input.

The two colours are held as six 16-bit component registers, loaded through one write port that carries a 6-bit select mask and a 16-bit data word. Every component is stored left-aligned. The output takes the top bits of the 16-bit value, as many as the selected depth of 6, 8, 10 or 12 bits per component, and places them right-aligned on a 12-bit output bus.

Top module: `patgen_core`

## Requirements
- R1: While reset is asserted, all three colour outputs read zero. Out of reset, colour 0 is white (all ones) and colour 1 is black (all zeros).
- R2: When `cw_we` is high, every component whose mask bit is set loads `cw_data` at the clock edge. The mask bits are bit 0 = colour 0 red, bit 1 = colour 0 green, bit 2 = colour 0 blue, bit 3 = colour 1 red, bit 4 = colour 1 green and bit 5 = colour 1 blue. More than one bit may be set at a time.
- R3: A write with an all-zero mask changes no component.
- R4: Component data is left-aligned in 16 bits. The output component equals the stored or computed 16-bit value shifted right by (16 − depth).
- R5: `pat_depth` codes 0, 1, 2 and 3 select 6, 8, 10 and 12 bits per component. Codes 4 to 7 select 8 bits. No output bit at or above the depth is ever set.
- R6: In mode 0 (vertical bars), a column uses colour 1 when bit `hres_sel` of `pix_x` is 1, and colour 0 otherwise.
- R7: In mode 1 (horizontal bars), a line uses colour 1 when bit `vres_sel` of `pix_y` is 1, and colour 0 otherwise.
- R8: In mode 2 (single ramp), all three components carry `pix_x · 2^(16−depth)`, saturated at 0xFFFF.
- R9: In mode 3 (dual ramp), lines where bit `vres_sel` of `pix_y` is 0 carry `24576 + pix_x · 2^(16−depth)`. Other lines carry `pix_x · 2^(18−depth)`. Both values saturate at 0xFFFF, and all three components are equal.
- R10: With `pat_en` low, the outputs equal the video inputs of the previous clock.
- R11: With `pat_en` high, the outputs reflect the pixel position, mode and colours of the previous clock. A colour write becomes visible in the next output sample after its edge.
- R12: A resolution select at or above the coordinate width picks a bit that is always 0, so colour 0 is shown everywhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_en | input | 1 | 1 = test pattern, 0 = video pass-through |
| pat_mode | input | 2 | 0 vertical bars, 1 horizontal bars, 2 single ramp, 3 dual ramp |
| pat_depth | input | 3 | Output depth code (see R5) |
| hres_sel | input | 4 | Column bit that selects the bar colour |
| vres_sel | input | 4 | Line bit that selects the bar colour or the ramp band |
| cw_we | input | 1 | Colour write strobe |
| cw_mask | input | 6 | Component select mask (see R2) |
| cw_data | input | 16 | Left-aligned component value |
| pix_x | input | CW | Current pixel column |
| pix_y | input | CW | Current line |
| vid_r | input | 12 | Input video red |
| vid_g | input | 12 | Input video green |
| vid_b | input | 12 | Input video blue |
| out_r | output | 12 | Output red |
| out_g | output | 12 | Output green |
| out_b | output | 12 | Output blue |

## Verification
A corrupted colour register does not show at once. It appears only when a bar of that colour is on screen, one clock after the pixel that selects it. The bench therefore reads back every component through both bar polarities right after loading it. A wrong depth decode or a wrong shift shows at the very next sample, either as stray bits above the depth or as a ramp step of the wrong size. The bench checks saturation and the dual-ramp offset at pixel positions where an error cannot cancel out. A pass-through that is stale or a cycle late is visible on the first sample after the enable falls.

// File: rtl/patgen_pkg.sv
package patgen_pkg;
  localparam int COL_W = 16;
  localparam int OUT_W = 12;
  localparam int NCOMP = 6;

  typedef enum logic [1:0] {
    PM_VBARS = 2'd0,
    PM_HBARS = 2'd1,
    PM_RAMP1 = 2'd2,
    PM_RAMP2 = 2'd3
  } pat_mode_e;

  localparam logic [COL_W-1:0] DUAL_BASE = 16'd24576;

  // depth code to bits per component; unknown codes fall back to 8
  function automatic logic [4:0] depth_of(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd6;
      3'd1:    return 5'd8;
      3'd2:    return 5'd10;
      3'd3:    return 5'd12;
      default: return 5'd8;
    endcase
  endfunction

  // keep the top d bits of a left-aligned value, right-aligned
  function automatic logic [OUT_W-1:0] narrow(input logic [COL_W-1:0] v,
                                              input logic [4:0] d);
    logic [COL_W-1:0] s;
    s = v >> (5'd16 - d);
    return s[OUT_W-1:0];
  endfunction

  function automatic logic sel_bit(input logic [COL_W-1:0] c,
                                   input logic [3:0] n);
    return c[n];
  endfunction

  // base + x * 2^inc, saturated to full scale
  function automatic logic [COL_W-1:0] ramp(input logic [COL_W-1:0] x,
                                            input logic [4:0] inc,
                                            input logic [COL_W-1:0] base);
    logic [32:0] acc;
    acc = {17'd0, base} + ({17'd0, x} << inc);
    if (acc > 33'h0FFFF) return 16'hFFFF;
    return acc[COL_W-1:0];
  endfunction
endpackage

// File: rtl/patgen_colour_bank.sv
module patgen_colour_bank #(
  parameter int NC   = 6,
  parameter int CWID = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [NC-1:0]            mask,
  input  logic [CWID-1:0]          data,
  output logic [NC-1:0][CWID-1:0]  col
);
  localparam int HALF = NC / 2;

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar i = 0; i < NC; i++) begin : g_comp
    localparam logic [CWID-1:0] RST_VAL = (i < HALF) ? '1 : '0;
    logic hit;
    assign hit = we & mask[i];

    always_ff @(posedge clk) begin
      if (!rst_n)   col[i] <= RST_VAL;
      else if (hit) col[i] <= data;
    end

    // R2: a selected component takes the written data
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(we && mask[i])) |-> col[i] == $past(data));
    // R3: an unselected component keeps its value
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(we && mask[i])) |-> $stable(col[i]));
  end
endmodule

// File: rtl/patgen_pixel.sv
module patgen_pixel
  import patgen_pkg::*;
(
  input  logic [1:0]                   mode,
  input  logic [2:0]                   depth_code,
  input  logic [3:0]                   hres,
  input  logic [3:0]                   vres,
  input  logic [COL_W-1:0]             x,
  input  logic [COL_W-1:0]             y,
  input  logic [NCOMP-1:0][COL_W-1:0]  col,
  output logic [OUT_W-1:0]             r,
  output logic [OUT_W-1:0]             g,
  output logic [OUT_W-1:0]             b,
  output logic                         use_c1,
  output logic [COL_W-1:0]             ramp_v
);
  logic [4:0] d, inc0, inc1;
  logic       vbar_hi, hbar_hi;
  logic [COL_W-1:0] ramp_single, ramp_lo, ramp_hi;

  assign d           = depth_of(depth_code);
  assign inc0        = 5'd16 - d;
  assign inc1        = inc0 + 5'd2;
  assign vbar_hi     = sel_bit(x, hres);
  assign hbar_hi     = sel_bit(y, vres);
  assign ramp_single = ramp(x, inc0, '0);
  assign ramp_lo     = ramp(x, inc0, DUAL_BASE);
  assign ramp_hi     = ramp(x, inc1, '0);

  always_comb begin
    use_c1 = 1'b0;
    ramp_v = '0;
    r = '0;
    g = '0;
    b = '0;
    case (pat_mode_e'(mode))
      PM_VBARS, PM_HBARS: begin
        use_c1 = (pat_mode_e'(mode) == PM_VBARS) ? vbar_hi : hbar_hi;
        r = narrow(use_c1 ? col[3] : col[0], d);
        g = narrow(use_c1 ? col[4] : col[1], d);
        b = narrow(use_c1 ? col[5] : col[2], d);
      end
      PM_RAMP1: begin
        ramp_v = ramp_single;
        r = narrow(ramp_v, d);
        g = r;
        b = r;
      end
      default: begin
        ramp_v = hbar_hi ? ramp_hi : ramp_lo;
        r = narrow(ramp_v, d);
        g = r;
        b = r;
      end
    endcase
  end
endmodule

// File: rtl/patgen_core.sv
module patgen_core
  import patgen_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pat_en,
  input  logic [1:0]       pat_mode,
  input  logic [2:0]       pat_depth,
  input  logic [3:0]       hres_sel,
  input  logic [3:0]       vres_sel,
  input  logic             cw_we,
  input  logic [5:0]       cw_mask,
  input  logic [15:0]      cw_data,
  input  logic [CW-1:0]    pix_x,
  input  logic [CW-1:0]    pix_y,
  input  logic [11:0]      vid_r,
  input  logic [11:0]      vid_g,
  input  logic [11:0]      vid_b,
  output logic [11:0]      out_r,
  output logic [11:0]      out_g,
  output logic [11:0]      out_b
);
  logic [NCOMP-1:0][COL_W-1:0] col;
  logic [OUT_W-1:0] pr, pg, pb;
  logic             use_c1;
  logic [COL_W-1:0] ramp_v;
  logic [4:0]       dbits;
  logic             armed;

  patgen_colour_bank #(.NC(NCOMP), .CWID(COL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cw_we), .mask(cw_mask),
    .data(cw_data), .col(col)
  );

  patgen_pixel u_pix (
    .mode(pat_mode), .depth_code(pat_depth), .hres(hres_sel), .vres(vres_sel),
    .x(COL_W'(pix_x)), .y(COL_W'(pix_y)), .col(col),
    .r(pr), .g(pg), .b(pb), .use_c1(use_c1), .ramp_v(ramp_v)
  );

  assign dbits = depth_of(pat_depth);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_r <= '0;
      out_g <= '0;
      out_b <= '0;
    end else if (pat_en) begin
      out_r <= pr;
      out_g <= pg;
      out_b <= pb;
    end else begin
      out_r <= vid_r;
      out_g <= vid_g;
      out_b <= vid_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R10: pass-through delivers last cycle's video
  assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(pat_en)) |->
      (out_r == $past(vid_r) && out_g == $past(vid_g) && out_b == $past(vid_b)));
  // R5: no output bit at or above the selected depth
  assert_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(pat_en)) |->
      ((out_r >> $past(dbits)) == 0 && (out_g >> $past(dbits)) == 0 &&
       (out_b >> $past(dbits)) == 0));
  // R8: ramps are grey
  assert_ramp_grey_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(pat_en && pat_mode[1])) |-> (out_r == out_g && out_g == out_b));
  // R6: bars never report a ramp value
  assert_bar_no_ramp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_mode[1] |-> ramp_v == '0);
endmodule

// File: tb/patgen_core_tb.sv
module patgen_core_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic pat_en = 0;
  logic [1:0] pat_mode = 0;
  logic [2:0] pat_depth = 0;
  logic [3:0] hres_sel = 0, vres_sel = 0;
  logic cw_we = 0;
  logic [5:0] cw_mask = 0;
  logic [15:0] cw_data = 0;
  logic [11:0] pix_x = 0, pix_y = 0;
  logic [11:0] vid_r = 0, vid_g = 0, vid_b = 0;
  logic [11:0] out_r, out_g, out_b;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int bc [6];

  always #5 clk = ~clk;

  patgen_core #(.CW(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .pat_en(pat_en), .pat_mode(pat_mode),
    .pat_depth(pat_depth), .hres_sel(hres_sel), .vres_sel(vres_sel),
    .cw_we(cw_we), .cw_mask(cw_mask), .cw_data(cw_data),
    .pix_x(pix_x), .pix_y(pix_y), .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  // mode, depth, hres, vres, x, y
  localparam logic [36:0] VEC [13] = '{
    {2'd0, 3'd1, 4'd6,  4'd6, 12'd10,   12'd0},   // R6 colour 0
    {2'd0, 3'd1, 4'd6,  4'd6, 12'd64,   12'd0},   // R6 colour 1
    {2'd0, 3'd0, 4'd3,  4'd6, 12'd8,    12'd0},   // R4 6-bit
    {2'd1, 3'd2, 4'd6,  4'd6, 12'd0,    12'd64},  // R7 colour 1
    {2'd1, 3'd3, 4'd6,  4'd2, 12'd0,    12'd3},   // R7 colour 0, 12-bit
    {2'd0, 3'd5, 4'd0,  4'd0, 12'd1,    12'd0},   // R5 unknown code
    {2'd2, 3'd1, 4'd0,  4'd0, 12'd5,    12'd0},   // R8
    {2'd2, 3'd0, 4'd0,  4'd0, 12'd70,   12'd0},   // R8 saturate
    {2'd3, 3'd2, 4'd0,  4'd6, 12'd3,    12'd0},   // R9 lower band
    {2'd3, 3'd2, 4'd0,  4'd6, 12'd3,    12'd64},  // R9 upper band
    {2'd3, 3'd2, 4'd0,  4'd6, 12'd300,  12'd64},  // R9 saturate
    {2'd0, 3'd3, 4'd15, 4'd0, 12'd4095, 12'd0},   // R12
    {2'd2, 3'd3, 4'd0,  4'd0, 12'd4095, 12'd0}    // R8 12-bit top
  };

  function automatic int rmp(int x, int inc, int base);
    int t;
    t = base + x * (1 << inc);
    return (t > 65535) ? 65535 : t;
  endfunction

  function automatic int expect_comp(int k, int md, int dc, int hr, int vr, int x, int y);
    int d, sh, v;
    d  = (dc < 4) ? 6 + 2 * dc : 8;
    sh = 16 - d;
    case (md)
      0: v = bc[((x >> hr) & 1) * 3 + k];
      1: v = bc[((y >> vr) & 1) * 3 + k];
      2: v = rmp(x, sh, 0);
      default: v = ((y >> vr) & 1) ? rmp(x, sh + 2, 0) : rmp(x, sh, 24576);
    endcase
    return v / (1 << sh);
  endfunction

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] m, logic [15:0] v);
    @(negedge clk);
    cw_we = 1; cw_mask = m; cw_data = v;
    @(negedge clk);
    cw_we = 0;
    for (int i = 0; i < 6; i++) if (m[i]) bc[i] = int'(v);
  endtask

  task automatic show(logic [1:0] md, logic [2:0] dc, logic [3:0] hr, logic [3:0] vr,
                      logic [11:0] x, logic [11:0] y);
    @(negedge clk);
    pat_en = 1; pat_mode = md; pat_depth = dc; hres_sel = hr; vres_sel = vr;
    pix_x = x; pix_y = y;
    @(negedge clk);
  endtask

  task automatic check_rgb(string tag);
    check({tag, " red"},   int'(out_r), expect_comp(0, pat_mode, pat_depth, hres_sel, vres_sel, pix_x, pix_y));
    check({tag, " green"}, int'(out_g), expect_comp(1, pat_mode, pat_depth, hres_sel, vres_sel, pix_x, pix_y));
    check({tag, " blue"},  int'(out_b), expect_comp(2, pat_mode, pat_depth, hres_sel, vres_sel, pix_x, pix_y));
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bc = '{65535, 65535, 65535, 0, 0, 0};
    vid_r = 12'hABC; vid_g = 12'h123; vid_b = 12'hFFF;
    repeat (3) @(negedge clk);
    // R1: zero outputs during reset
    check("R1 reset red", int'(out_r), 0);
    check("R1 reset green", int'(out_g), 0);
    check("R1 reset blue", int'(out_b), 0);
    rst_n = 1;

    // R1: default white/black
    show(2'd0, 3'd1, 4'd6, 4'd6, 12'd0, 12'd0);
    check_rgb("R1 default colour 0");
    check("R1 white", int'(out_r), 255);
    show(2'd0, 3'd1, 4'd6, 4'd6, 12'd64, 12'd0);
    check_rgb("R1 default colour 1");
    check("R1 black", int'(out_g), 0);

    // R2: load each component on its own mask bit
    wr(6'b000001, 16'hABCD);
    wr(6'b000010, 16'h5A00);
    wr(6'b000100, 16'h0FF0);
    wr(6'b001000, 16'h8000);
    wr(6'b010000, 16'h00FF);
    wr(6'b100000, 16'hFFFF);
    show(2'd0, 3'd3, 4'd6, 4'd6, 12'd0, 12'd0);
    check_rgb("R2 colour 0 readback");
    show(2'd0, 3'd3, 4'd6, 4'd6, 12'd64, 12'd0);
    check_rgb("R2 colour 1 readback");

    // table walk
    for (int i = 0; i < 13; i++) begin
      show(VEC[i][36:35], VEC[i][34:32], VEC[i][31:28], VEC[i][27:24],
           VEC[i][23:12], VEC[i][11:0]);
      check_rgb($sformatf("vector %0d", i));
    end

    // R3: zero mask write leaves colours
    wr(6'b000000, 16'h0000);
    show(2'd0, 3'd3, 4'd6, 4'd6, 12'd0, 12'd0);
    check_rgb("R3 colour 0 after empty write");
    show(2'd0, 3'd3, 4'd6, 4'd6, 12'd64, 12'd0);
    check_rgb("R3 colour 1 after empty write");

    // R2: two bits at once
    wr(6'b001001, 16'h1230);
    show(2'd0, 3'd1, 4'd6, 4'd6, 12'd0, 12'd0);
    check("R2 multi R0", int'(out_r), 8'h12);
    show(2'd0, 3'd1, 4'd6, 4'd6, 12'd64, 12'd0);
    check("R2 multi R1", int'(out_r), 8'h12);

    // R11: colour write visible one sample after its edge
    @(negedge clk);
    pix_x = 12'd0; cw_we = 1; cw_mask = 6'b000001; cw_data = 16'h7700;
    @(negedge clk);
    cw_we = 0; bc[0] = 32'h7700;
    check("R11 write not yet visible", int'(out_r), 8'h12);
    @(negedge clk);
    check("R11 write visible", int'(out_r), 8'h77);

    // R10: pass-through with one clock of latency
    @(negedge clk);
    pat_en = 0;
    @(negedge clk);
    check("R10 pass red", int'(out_r), 12'hABC);
    check("R10 pass green", int'(out_g), 12'h123);
    check("R10 pass blue", int'(out_b), 12'hFFF);
    vid_r = 12'h456;
    #1;
    check("R10 latency hold", int'(out_r), 12'hABC);
    @(negedge clk);
    check("R10 latency update", int'(out_r), 12'h456);

    // R11: pattern follows position with one clock latency
    show(2'd2, 3'd1, 4'd0, 4'd0, 12'd9, 12'd0);
    pix_x = 12'd20;
    #1;
    check("R11 pattern hold", int'(out_r), 9);
    @(negedge clk);
    check("R11 pattern update", int'(out_r), 20);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule